// File: doc/BRIEF.md
# Host Boot Command Sequencer

This block runs the boot flow behind an 8-bit parallel host port. When reset is released with the external-memory select input low, the fetch address points at the boot vector. One cycle later it moves to the command-loop address. The block then waits for the host to write a command byte. Each byte is classified against a set of parameterised codes. A command may start a download or memory-test engine through a start/done/abort interface, switch the PLL enable on or off, or fall through when the code is unknown.

Every operation ends by loading a fixed acknowledge byte into the host output register and raising the output-buffer-full flag. This applies whether the operation finished normally or was cut short by the asynchronous abort input. The block then stalls until the host reads that byte. It ignores any command strobe during this wait. After the read, the port returns to 8-bit single-transfer mode and the next command is accepted.

Two jump commands end the boot flow. Each one pulses a one-cycle exit strobe with a 20-bit start address: internal RAM at 0x00000 or external ROM at 0x80000. No acknowledge byte is sent for a jump. On exit the host-port mode is restored to its reset value, but the PLL enable keeps whatever value it held.

Top module: `boot_cmd_ctrl`

## Requirements
- R1: In reset and in the first cycle after reset, `fetch_addr` is 0x20000. With `ext_mem_sel` low it becomes 0x20400 one cycle later and stays there while commands are being handled.
- R2: While waiting, a one-cycle `host_wr_stb` captures `host_din` onto `op_cmd`. In the following cycle, codes 0x01, 0x02 and 0x03 (download RAM, download external, memory test) pulse `op_start` for one cycle.
- R3: After reset, `port_8bit` is high and `pll_en` is low while the block waits for a command. `port_8bit` is low while an engine operation is running.
- R4: A running operation continues, with no acknowledge, until `op_done` is seen. On the next cycle the acknowledge is presented.
- R5: A rising edge of `abort_irq`, after two synchronising flops, ends a running operation. It pulses `op_abort` and produces the acknowledge. An abort edge that arrives while no operation runs has no effect on the next operation.
- R6: An acknowledge drives `host_dout` to 0xED with `obuf_full` high.
- R7: `obuf_full` stays high until `host_rd_stb`. After the read, `obuf_full` is low, `port_8bit` is high and a new command is accepted.
- R8: Code 0x06 pulses `exit_stb` with `exit_addr` 0x00000. Code 0x07 pulses it with 0x80000. After either, `fetch_addr` holds that address, and no acknowledge is sent.
- R9: After a jump, `port_8bit` is high and `pll_en` keeps its value from before the jump.
- R10: Code 0x04 sets `pll_en` and code 0x05 clears it. Both are acknowledged.
- R11: Any other code is acknowledged directly, without `op_start`.
- R12: `host_wr_stb` while busy or awaiting the acknowledge read leaves `op_cmd` unchanged.
- R13: With `ext_mem_sel` high at reset release, `fetch_addr` goes to 0x80000 and commands are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mem_sel | input | 1 | Boot from external memory instead of the command loop |
| host_din | input | 8 | Command byte from host |
| host_wr_stb | input | 1 | Host input data strobe, one cycle |
| host_rd_stb | input | 1 | Host read of the output register, one cycle |
| host_dout | output | 8 | Host output register |
| obuf_full | output | 1 | Output register holds an unread byte |
| port_8bit | output | 1 | Host port in 8-bit single-transfer mode |
| pll_en | output | 1 | PLL enable |
| abort_irq | input | 1 | Asynchronous abort request |
| op_start | output | 1 | One-cycle start to the engine |
| op_cmd | output | 8 | Captured command byte for the engine |
| op_done | input | 1 | Engine finished |
| op_abort | output | 1 | One-cycle abort to the engine |
| fetch_addr | output | 20 | Current fetch address |
| exit_stb | output | 1 | Boot exit strobe |
| exit_addr | output | 20 | User start address |

## Verification
The assertions take several things for granted about the inputs. `op_done` is raised only while an operation runs. The host strobes are single-cycle and synchronous to `clk`. `abort_irq` is held long enough to pass the synchroniser. The bench drives every input at the falling edge, pulses each strobe for exactly one cycle, and asserts `op_done` only after it has seen `port_8bit` low. It keeps `abort_irq` high for several cycles before releasing it. The sweep resets the block before each of the 256 codes, so every code starts from the command-wait state.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    K_UNDEF, K_OP, K_PLL_ON, K_PLL_OFF, K_JMP_RAM, K_JMP_ROM
  } cmd_kind_t;

  typedef enum logic [2:0] {
    ST_VEC, ST_WAIT, ST_EXEC, ST_BUSY, ST_HOLD, ST_EXIT
  } boot_state_t;

  function automatic logic kind_acks(cmd_kind_t k);
    return (k == K_UNDEF) || (k == K_PLL_ON) || (k == K_PLL_OFF);
  endfunction

  function automatic logic kind_jumps(cmd_kind_t k);
    return (k == K_JMP_RAM) || (k == K_JMP_ROM);
  endfunction
endpackage

// File: rtl/boot_abort_sync.sv
module boot_abort_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last_q;

  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/boot_cmd_decode.sv
module boot_cmd_decode
  import boot_pkg::*;
#(
  parameter logic [7:0] C_DL_RAM  = 8'h01,
  parameter logic [7:0] C_DL_EXT  = 8'h02,
  parameter logic [7:0] C_MTEST   = 8'h03,
  parameter logic [7:0] C_PLL_ON  = 8'h04,
  parameter logic [7:0] C_PLL_OFF = 8'h05,
  parameter logic [7:0] C_JMP_RAM = 8'h06,
  parameter logic [7:0] C_JMP_ROM = 8'h07
) (
  input  logic [7:0] cmd,
  output cmd_kind_t  kind
);
  always_comb begin
    if (cmd == C_DL_RAM || cmd == C_DL_EXT || cmd == C_MTEST) kind = K_OP;
    else if (cmd == C_PLL_ON)  kind = K_PLL_ON;
    else if (cmd == C_PLL_OFF) kind = K_PLL_OFF;
    else if (cmd == C_JMP_RAM) kind = K_JMP_RAM;
    else if (cmd == C_JMP_ROM) kind = K_JMP_ROM;
    else                       kind = K_UNDEF;
  end
endmodule

// File: rtl/boot_ack_port.sv
module boot_ack_port #(
  parameter int         DW       = 8,
  parameter logic [7:0] ACK_BYTE = 8'hED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          rd_stb,
  output logic [DW-1:0] dout,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
      full <= 1'b0;
    end else if (load) begin
      dout <= DW'(ACK_BYTE);
      full <= 1'b1;
    end else if (rd_stb && full) begin
      full <= 1'b0;
    end
  end

  a_r6_ack_value: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> dout == DW'(ACK_BYTE));
  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_stb) |=> full);
endmodule

// File: rtl/boot_cmd_ctrl.sv
module boot_cmd_ctrl
  import boot_pkg::*;
#(
  parameter int          AW        = 20,
  parameter logic [19:0] BOOT_VEC  = 20'h20000,
  parameter logic [19:0] LOOP_VEC  = 20'h20400,
  parameter logic [19:0] RAM_BASE  = 20'h00000,
  parameter logic [19:0] ROM_BASE  = 20'h80000,
  parameter logic [7:0]  ACK_BYTE  = 8'hED,
  parameter logic [7:0]  C_DL_RAM  = 8'h01,
  parameter logic [7:0]  C_DL_EXT  = 8'h02,
  parameter logic [7:0]  C_MTEST   = 8'h03,
  parameter logic [7:0]  C_PLL_ON  = 8'h04,
  parameter logic [7:0]  C_PLL_OFF = 8'h05,
  parameter logic [7:0]  C_JMP_RAM = 8'h06,
  parameter logic [7:0]  C_JMP_ROM = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mem_sel,
  input  logic [7:0]    host_din,
  input  logic          host_wr_stb,
  input  logic          host_rd_stb,
  output logic [7:0]    host_dout,
  output logic          obuf_full,
  output logic          port_8bit,
  output logic          pll_en,
  input  logic          abort_irq,
  output logic          op_start,
  output logic [7:0]    op_cmd,
  input  logic          op_done,
  output logic          op_abort,
  output logic [AW-1:0] fetch_addr,
  output logic          exit_stb,
  output logic [AW-1:0] exit_addr
);
  boot_state_t   state;
  cmd_kind_t     kind;
  logic [7:0]    cmd_q;
  logic          pll_q;
  logic [AW-1:0] exit_q;
  logic [AW-1:0] jump_target;
  logic          abort_rise;
  logic          in_exec, in_busy, op_end, ack_load;

  boot_abort_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(abort_irq), .rise(abort_rise));

  boot_cmd_decode #(
    .C_DL_RAM(C_DL_RAM), .C_DL_EXT(C_DL_EXT), .C_MTEST(C_MTEST),
    .C_PLL_ON(C_PLL_ON), .C_PLL_OFF(C_PLL_OFF),
    .C_JMP_RAM(C_JMP_RAM), .C_JMP_ROM(C_JMP_ROM)
  ) u_dec (.cmd(cmd_q), .kind(kind));

  // Named events used by the FSM and the assertions.
  assign in_exec     = (state == ST_EXEC);
  assign in_busy     = (state == ST_BUSY);
  assign op_end      = in_busy && (op_done || abort_rise);
  assign ack_load    = (in_exec && kind_acks(kind)) || op_end;
  assign jump_target = (kind == K_JMP_ROM) ? AW'(ROM_BASE) : AW'(RAM_BASE);

  boot_ack_port #(.DW(8), .ACK_BYTE(ACK_BYTE)) u_ack (
    .clk(clk), .rst_n(rst_n), .load(ack_load), .rd_stb(host_rd_stb),
    .dout(host_dout), .full(obuf_full));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_VEC;
      cmd_q  <= '0;
      pll_q  <= 1'b0;
      exit_q <= '0;
    end else begin
      unique case (state)
        ST_VEC: begin
          if (ext_mem_sel) begin
            exit_q <= AW'(ROM_BASE);
            state  <= ST_EXIT;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (host_wr_stb) begin
          cmd_q <= host_din;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (kind == K_OP) state <= ST_BUSY;
          else if (kind_jumps(kind)) begin
            exit_q <= jump_target;
            state  <= ST_EXIT;
          end else begin
            if (kind == K_PLL_ON)  pll_q <= 1'b1;
            if (kind == K_PLL_OFF) pll_q <= 1'b0;
            state <= ST_HOLD;
          end
        end
        ST_BUSY: if (op_done || abort_rise) state <= ST_HOLD;
        ST_HOLD: if (host_rd_stb) state <= ST_WAIT;
        ST_EXIT: state <= ST_EXIT;
        default: state <= ST_VEC;
      endcase
    end
  end

  assign op_cmd    = cmd_q;
  assign op_start  = in_exec && (kind == K_OP);
  assign op_abort  = in_busy && abort_rise;
  assign exit_stb  = in_exec && kind_jumps(kind);
  assign exit_addr = exit_stb ? jump_target : exit_q;
  assign port_8bit = !in_busy;
  assign pll_en    = pll_q;
  assign fetch_addr = (state == ST_VEC)  ? AW'(BOOT_VEC) :
                      (state == ST_EXIT) ? exit_q : AW'(LOOP_VEC);

  a_r1_loop_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VEC && !ext_mem_sel) |=> fetch_addr == AW'(LOOP_VEC));
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start && !port_8bit);
  a_r3_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !port_8bit |-> !obuf_full);
  a_r5_abort_acks: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |=> obuf_full);
  a_r8_jump_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    exit_stb |=> !obuf_full && !exit_stb && fetch_addr == $past(exit_addr));
  a_r12_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (obuf_full && host_wr_stb) |=> $stable(op_cmd));
endmodule

// File: tb/boot_cmd_ctrl_test.sv
module boot_cmd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mem_sel = 1'b0;
  logic [7:0]  host_din = '0;
  logic        host_wr_stb = 1'b0, host_rd_stb = 1'b0;
  logic [7:0]  host_dout;
  logic        obuf_full, port_8bit, pll_en;
  logic        abort_irq = 1'b0;
  logic        op_start, op_abort, exit_stb;
  logic [7:0]  op_cmd;
  logic        op_done = 1'b0;
  logic [19:0] fetch_addr, exit_addr;
  int          n_run = 0, n_fail = 0;
  bit          ended = 0;

  always #4 clk = ~clk;

  boot_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_mem_sel(ext_mem_sel),
    .host_din(host_din), .host_wr_stb(host_wr_stb), .host_rd_stb(host_rd_stb),
    .host_dout(host_dout), .obuf_full(obuf_full), .port_8bit(port_8bit),
    .pll_en(pll_en), .abort_irq(abort_irq), .op_start(op_start),
    .op_cmd(op_cmd), .op_done(op_done), .op_abort(op_abort),
    .fetch_addr(fetch_addr), .exit_stb(exit_stb), .exit_addr(exit_addr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit ext);
    rst_n = 1'b0; ext_mem_sel = ext;
    cyc(2);
    rst_n = 1'b1;
    check(fetch_addr == 20'h20000, "R1 first cycle", int'(fetch_addr), 'h20000);
    cyc(1);
  endtask

  // Drive one command; returns at the cycle where it is being decoded.
  task automatic send(input logic [7:0] b);
    host_din = b; host_wr_stb = 1'b1;
    cyc(1);
    host_wr_stb = 1'b0;
  endtask

  task automatic read_ack();
    host_rd_stb = 1'b1; cyc(1); host_rd_stb = 1'b0;
    check(!obuf_full && port_8bit, "R7 released", int'(obuf_full), 0);
    check(fetch_addr == 20'h20400, "R1 loop addr", int'(fetch_addr), 'h20400);
  endtask

  task automatic expect_ack(input string req);
    check(obuf_full == 1'b1, req, int'(obuf_full), 1);
    check(host_dout == 8'hED, "R6 ack byte", int'(host_dout), 'hED);
  endtask

  // Bench model of the command code map.
  function automatic int cls(input int c);
    if (c >= 1 && c <= 3) return 1;
    if (c >= 4 && c <= 7) return c - 2;
    return 0;
  endfunction

  initial begin
    cyc(1);
    check(fetch_addr == 20'h20000, "R1 in reset", int'(fetch_addr), 'h20000);
    check(!obuf_full && !exit_stb && !op_start, "R1 reset quiet", int'(obuf_full), 0);

    // Sweep every code from a fresh reset.
    for (int c = 0; c < 256; c++) begin
      int k;
      k = cls(c);
      do_reset(1'b0);
      check(fetch_addr == 20'h20400, "R1 loop addr", int'(fetch_addr), 'h20400);
      check(port_8bit && !pll_en, "R3 wait state", int'({port_8bit, pll_en}), 2);
      send(8'(c));
      check(op_cmd == 8'(c), "R2 capture", int'(op_cmd), c);
      check(op_start == (k == 1), "R2 R11 start", int'(op_start), int'(k == 1));
      check(exit_stb == (k >= 4), "R8 exit strobe", int'(exit_stb), int'(k >= 4));
      if (k >= 4)
        check(exit_addr == ((k == 5) ? 20'h80000 : 20'h0), "R8 exit addr",
              int'(exit_addr), (k == 5) ? 'h80000 : 0);
      cyc(1);
      if (k == 1) begin
        check(!port_8bit && !op_start, "R3 busy mode", int'(port_8bit), 0);
        cyc(3);
        check(!obuf_full, "R4 runs until done", int'(obuf_full), 0);
        op_done = 1'b1; cyc(1); op_done = 1'b0;
        expect_ack("R4 ack after done");
        read_ack();
      end else if (k >= 4) begin
        check(!obuf_full && !exit_stb, "R8 no ack", int'(obuf_full), 0);
        check(fetch_addr == ((k == 5) ? 20'h80000 : 20'h0), "R8 fetch target",
              int'(fetch_addr), (k == 5) ? 'h80000 : 0);
        check(port_8bit, "R9 port mode", int'(port_8bit), 1);
      end else begin
        expect_ack((k == 0) ? "R11 direct ack" : "R10 pll ack");
        check(pll_en == (k == 2), "R10 pll", int'(pll_en), int'(k == 2));
        read_ack();
      end
    end

    // Stall, ignored strobes, PLL retention through exit.
    do_reset(1'b0);
    send(8'h04); cyc(1);
    send(8'h06); cyc(4);
    check(obuf_full, "R7 stall", int'(obuf_full), 1);
    check(op_cmd == 8'h04, "R12 strobe ignored in hold", int'(op_cmd), 4);
    read_ack();
    send(8'h05); cyc(1);
    check(!pll_en, "R10 pll off", int'(pll_en), 0);
    read_ack();
    send(8'h04); cyc(1); read_ack();
    send(8'h07); cyc(1);
    check(pll_en && port_8bit, "R9 pll kept on exit", int'(pll_en), 1);
    check(fetch_addr == 20'h80000, "R8 rom exit", int'(fetch_addr), 'h80000);

    // Abort during an operation; strobe while busy is ignored.
    do_reset(1'b0);
    send(8'h02); cyc(1);
    send(8'h55);
    check(op_cmd == 8'h02, "R12 strobe ignored busy", int'(op_cmd), 2);
    abort_irq = 1'b1; cyc(5); abort_irq = 1'b0;
    expect_ack("R5 abort acks");
    read_ack();

    // Abort while idle does not hit the next operation.
    abort_irq = 1'b1; cyc(5); abort_irq = 1'b0; cyc(3);
    send(8'h03); cyc(6);
    check(!obuf_full && !port_8bit, "R5 stale abort ignored", int'(obuf_full), 0);
    op_done = 1'b1; cyc(1); op_done = 1'b0;
    expect_ack("R5 done after stale abort");

    // External memory boot.
    do_reset(1'b1);
    check(fetch_addr == 20'h80000, "R13 ext boot", int'(fetch_addr), 'h80000);
    send(8'h04); cyc(2);
    check(!pll_en && !obuf_full, "R13 no commands", int'(pll_en), 0);

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule